// File: doc/BRIEF.md
# CAN Bit Timing Calculator

This block turns a peripheral clock frequency and a requested bus bit rate into the packed bit-timing word that a CAN controller loads before it leaves reset. A single pulse on `start` captures both numbers and the triple-sample option. An iterative divider then finds how many peripheral clocks fit in one bit.

When that ratio is large, the bit is built from fourteen time quanta: one sync quantum, a first phase segment of six and a second of seven. The prescaler is the ratio divided by fourteen, rounded to the nearest value, which takes a second pass through the same divider. When the ratio is small, the prescaler is forced to one. The available clocks are then split into two segments of nearly equal length, and the split is skewed by one quantum when both halves come out equal.

Impossible requests raise an error flag and produce an all-zero word. These are a zero bit rate, a ratio too small for any valid split, and a prescaler beyond the ten-bit field. `ready` is low while a calculation runs. The last result stays on the outputs until the next accepted start.

Top module: `can_bt_calc`

## Requirements
- R1: The ratio is the integer quotient floor(clk_hz / baud), taken from the values captured when start is accepted.
- R2: For a ratio of 14 or more, segment one is 6 quanta, segment two is 7 quanta and the prescaler is floor((ratio + 7) / 14).
- R3: For a ratio from 3 to 13, the prescaler is 1, segment one is (ratio - 1) >> 1 and segment two is ratio - 1 - segment one.
- R4: In the small-ratio case, when the two segments are equal and segment one is greater than 1, segment one loses one quantum and segment two gains it.
- R5: The resynchronisation jump width is always 1 quantum, so its field is always 0.
- R6: Word layout: bits [9:0] hold prescaler-1, bits [15:14] hold jump width-1, bits [19:16] hold segment one-1, bits [22:20] hold segment two-1, and bit 23 holds the triple_sample value captured at start. All other bits are 0.
- R7: A prescaler above 1023 sets cfg_error and forces the word to zero.
- R8: A baud of zero, or a ratio below 3, sets cfg_error and forces the word to zero. A successful result clears cfg_error.
- R9: ready is high when idle and low during a calculation. Counting clock edges after the one that accepts start, ready returns high after CLK_W+2 edges for a ratio below 14 and after 2*CLK_W+4 edges otherwise. A zero baud is answered on the accepting edge itself, and ready stays high.
- R10: A start while ready is low is ignored. While ready is high and start is low, timing_word and cfg_error hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calculation; accepted only while ready is high |
| clk_hz | input | CLK_W | Peripheral clock frequency in Hz |
| baud | input | BAUD_W | Requested bit rate in bit/s |
| triple_sample | input | 1 | Selects three-sample mode in the output word |
| ready | output | 1 | Idle and result valid |
| timing_word | output | 32 | Packed bit-timing word |
| cfg_error | output | 1 | The last request had no valid setting |

## Verification
Each result has a fixed latency. A zero-baud request is answered on the edge that accepts start. A small-ratio request, or one rejected for a ratio below 3, is answered CLK_W+2 edges later. A fourteen-quantum request, or one rejected for prescaler overflow, needs 2*CLK_W+4 edges because of the second division.

The bench drives inputs on falling edges and counts falling edges until ready returns. It compares that count with the latency the requirements predict for the case, and only then samples the word and flag. A start pulsed mid-calculation and a long idle stretch with changing inputs are both checked at the ports once ready is high.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RATIO = 2'd1,
        ST_PRESC = 2'd2
    } calc_state_e;

    localparam int WORD_W     = 32;
    localparam int BRP_W      = 10;
    localparam int SJW_W      = 2;
    localparam int TS1_W      = 4;
    localparam int TS2_W      = 3;
    localparam int SEG_W      = 4;

    // Field positions are decoded by the controller that loads the word.
    localparam int BRP_LSB    = 0;
    localparam int SJW_LSB    = 14;
    localparam int TS1_LSB    = 16;
    localparam int TS2_LSB    = 20;
    localparam int SAM_BIT    = 23;

    localparam int QUANTA_NOM = 14;
    localparam int TS1_NOM    = 6;
    localparam int TS2_NOM    = 7;
    localparam int RATIO_MIN  = 3;
    localparam int BRP_MAX    = 1023;

    function automatic logic [WORD_W-1:0] pack_word(
        input logic [BRP_W-1:0] brp,
        input logic [SEG_W-1:0] seg1,
        input logic [SEG_W-1:0] seg2,
        input logic             sam
    );
        logic [WORD_W-1:0] w;
        logic [BRP_W-1:0]  brp_m1;
        logic [SEG_W-1:0]  s1_m1;
        logic [SEG_W-1:0]  s2_m1;
        brp_m1 = brp - 1'b1;
        s1_m1  = seg1 - 1'b1;
        s2_m1  = seg2 - 1'b1;
        w = '0;
        w[BRP_LSB +: BRP_W] = brp_m1;
        w[SJW_LSB +: SJW_W] = '0;
        w[TS1_LSB +: TS1_W] = s1_m1[TS1_W-1:0];
        w[TS2_LSB +: TS2_W] = s2_m1[TS2_W-1:0];
        w[SAM_BIT]          = sam;
        return w;
    endfunction

endpackage

// File: rtl/can_bt_divider.sv
module can_bt_divider #(
    parameter int W = 33
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  dvd;
        logic [W-1:0]  dvs;
        logic          done;
    } div_regs_t;

    div_regs_t r_q, r_d;
    logic [W:0] rem_sh;
    logic [W:0] trial;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        rem_sh   = {r_q.rem, r_q.quo[W-1]};
        trial    = rem_sh - {1'b0, r_q.dvs};
        if (go) begin
            r_d.busy = 1'b1;
            r_d.cnt  = CW'(W);
            r_d.rem  = '0;
            r_d.quo  = dividend;
            r_d.dvd  = dividend;
            r_d.dvs  = divisor;
        end else if (r_q.busy) begin
            if (trial[W]) begin
                r_d.rem = rem_sh[W-1:0];
                r_d.quo = {r_q.quo[W-2:0], 1'b0};
            end else begin
                r_d.rem = trial[W-1:0];
                r_d.quo = {r_q.quo[W-2:0], 1'b1};
            end
            r_d.cnt = r_q.cnt - 1'b1;
            if (r_q.cnt == CW'(1)) begin
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done     = r_q.done;
    assign quotient = r_q.quo;

    AST_DIV_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> ((((2*W)'(r_q.quo) * (2*W)'(r_q.dvs)) + (2*W)'(r_q.rem)) == (2*W)'(r_q.dvd))
                     && (r_q.rem < r_q.dvs)); // R1

    AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (divisor != '0)); // R8

endmodule

// File: rtl/can_bt_split.sv
module can_bt_split
    import can_bt_pkg::*;
(
    input  logic [SEG_W-1:0] ratio_lo,
    output logic [SEG_W-1:0] seg1,
    output logic [SEG_W-1:0] seg2
);
    logic [SEG_W-1:0] half;
    logic [SEG_W-1:0] rest;

    always_comb begin
        half = (ratio_lo - 1'b1) >> 1;
        rest = ratio_lo - half - 1'b1;
        if ((half == rest) && (half > SEG_W'(1))) begin
            seg1 = half - 1'b1;
            seg2 = rest + 1'b1;
        end else begin
            seg1 = half;
            seg2 = rest;
        end
    end

endmodule

// File: rtl/can_bt_calc.sv
module can_bt_calc
    import can_bt_pkg::*;
#(
    parameter int CLK_W  = 32,
    parameter int BAUD_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CLK_W-1:0]  clk_hz,
    input  logic [BAUD_W-1:0] baud,
    input  logic              triple_sample,
    output logic              ready,
    output logic [31:0]       timing_word,
    output logic              cfg_error
);
    localparam int DW = CLK_W + 1;

    typedef struct packed {
        calc_state_e       state;
        logic [WORD_W-1:0] word;
        logic              err;
        logic              sam;
    } calc_regs_t;

    calc_regs_t r_q, r_d;

    logic          div_go;
    logic [DW-1:0] div_a;
    logic [DW-1:0] div_b;
    logic          div_done;
    logic [DW-1:0] div_q;
    logic [SEG_W-1:0] seg1;
    logic [SEG_W-1:0] seg2;

    can_bt_divider #(.W(DW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (div_a),
        .divisor  (div_b),
        .done     (div_done),
        .quotient (div_q)
    );

    can_bt_split u_split (
        .ratio_lo (div_q[SEG_W-1:0]),
        .seg1     (seg1),
        .seg2     (seg2)
    );

    always_comb begin
        r_d    = r_q;
        div_go = 1'b0;
        div_a  = '0;
        div_b  = '0;
        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.sam = triple_sample;
                    if (baud == '0) begin
                        r_d.err  = 1'b1;
                        r_d.word = '0;
                    end else begin
                        div_go    = 1'b1;
                        div_a     = DW'(clk_hz);
                        div_b     = DW'(baud);
                        r_d.state = ST_RATIO;
                    end
                end
            end
            ST_RATIO: begin
                if (div_done) begin
                    if (div_q < DW'(RATIO_MIN)) begin
                        r_d.err   = 1'b1;
                        r_d.word  = '0;
                        r_d.state = ST_IDLE;
                    end else if (div_q < DW'(QUANTA_NOM)) begin
                        r_d.err   = 1'b0;
                        r_d.word  = pack_word(BRP_W'(1), seg1, seg2, r_q.sam);
                        r_d.state = ST_IDLE;
                    end else begin
                        div_go    = 1'b1;
                        div_a     = div_q + DW'(QUANTA_NOM / 2);
                        div_b     = DW'(QUANTA_NOM);
                        r_d.state = ST_PRESC;
                    end
                end
            end
            ST_PRESC: begin
                if (div_done) begin
                    if ((div_q == '0) || (div_q > DW'(BRP_MAX))) begin
                        r_d.err  = 1'b1;
                        r_d.word = '0;
                    end else begin
                        r_d.err  = 1'b0;
                        r_d.word = pack_word(div_q[BRP_W-1:0], SEG_W'(TS1_NOM),
                                             SEG_W'(TS2_NOM), r_q.sam);
                    end
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, word: '0, err: 1'b0, sam: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ready       = (r_q.state == ST_IDLE);
    assign timing_word = r_q.word;
    assign cfg_error   = r_q.err;

    AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start && (baud != '0)) |=> !ready); // R9

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !start) |=> ($stable(timing_word) && $stable(cfg_error))); // R10

    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && cfg_error) |-> (timing_word == '0)); // R8

    AST_SJW_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (timing_word[SJW_LSB +: SJW_W] == '0)); // R5

    AST_SEG_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !cfg_error) |->
            ((timing_word[TS2_LSB +: TS2_W] >= 3'(timing_word[TS1_LSB +: TS1_W]))
             && ((5'(timing_word[TS1_LSB +: TS1_W]) + 5'(timing_word[TS2_LSB +: TS2_W]))
                 <= 5'(QUANTA_NOM - 3)))); // R3

endmodule

// File: tb/sim_can_bt_calc.sv
module sim_can_bt_calc;
    localparam int CW = 16;
    localparam int BW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] clk_hz = '0;
    logic [BW-1:0] baud = '0;
    logic          triple_sample = 1'b0;
    logic          ready;
    logic [31:0]   timing_word;
    logic          cfg_error;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    can_bt_calc #(.CLK_W(CW), .BAUD_W(BW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .clk_hz(clk_hz), .baud(baud),
        .triple_sample(triple_sample), .ready(ready), .timing_word(timing_word),
        .cfg_error(cfg_error)
    );

    function automatic logic [32:0] model(input int c, input int b, input bit s);
        int r, t1, t2, brp;
        logic [31:0] w;
        if (b == 0) return {1'b1, 32'h0};
        r = c / b;
        if (r < 3) return {1'b1, 32'h0};
        if (r < 14) begin
            brp = 1;
            t1 = (r - 1) >> 1;
            t2 = r - t1 - 1;
            if (t1 == t2 && t1 > 1) begin
                t1 = t1 - 1;
                t2 = t2 + 1;
            end
        end else begin
            t1 = 6;
            t2 = 7;
            brp = (r + 7) / 14;
            if (brp > 1023) return {1'b1, 32'h0};
        end
        w = 32'(brp - 1) | (32'(t1 - 1) << 16) | (32'(t2 - 1) << 20) | (32'(s) << 23);
        return {1'b0, w};
    endfunction

    function automatic int latency(input int c, input int b);
        if (b == 0) return 0;
        if ((c / b) < 14) return CW + 2;
        return 2 * CW + 4;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!ready && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run(input int c, input int b, input bit s);
        int n;
        logic [32:0] e;
        string tag;
        @(negedge clk);
        clk_hz = CW'(c);
        baud = BW'(b);
        triple_sample = s;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_ready(n);
        e = model(c, b, s);
        check(n == latency(c, b), "R9 latency", 64'(n), 64'(latency(c, b)));
        if (b == 0 || (c / b) < 3) tag = "R8 error";
        else if ((c / b) >= 14 && ((c / b) + 7) / 14 > 1023) tag = "R7 overflow";
        else if ((c / b) >= 14) tag = "R1 R2 R5 R6 nominal";
        else tag = "R1 R3 R4 R5 R6 small";
        check({cfg_error, timing_word} == e, tag, 64'({cfg_error, timing_word}), 64'(e));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !finished) begin
            finished = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<190000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        logic [32:0] e;
        logic [31:0] held;
        int clks [7] = '{0, 2, 40, 700, 14328, 14329, 65535};
        repeat (3) @(negedge clk);
        check(ready == 1'b1 && cfg_error == 1'b0 && timing_word == 32'h0, "R9 reset",
              64'({ready, cfg_error, timing_word}), 64'({1'b1, 1'b0, 32'h0}));
        rst_n = 1'b1;
        @(negedge clk);

        foreach (clks[i]) begin
            for (int b = 0; b < 256; b++) begin
                run(clks[i], b, b[0]);
            end
        end

        // R10: start pulsed while busy is ignored
        @(negedge clk);
        clk_hz = 16'd700; baud = 8'd10; triple_sample = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        clk_hz = 16'd40; baud = 8'd1; triple_sample = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_ready(n);
        e = model(700, 10, 1'b1);
        check({cfg_error, timing_word} == e, "R10 busy start ignored",
              64'({cfg_error, timing_word}), 64'(e));

        // R10: outputs hold while idle with changing inputs
        held = timing_word;
        for (int k = 0; k < 25; k++) begin
            clk_hz = CW'(k * 977);
            baud = BW'(k + 1);
            triple_sample = k[0];
            @(negedge clk);
        end
        check(ready && timing_word == held && cfg_error == e[32], "R10 hold",
              64'({ready, cfg_error, timing_word}), 64'({1'b1, e[32], held}));

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule